// File: doc/BRIEF.md
# Addressable Bit-Bus Slave Latch

This block is a slave on a one-bit serial register bus. The bus carries a 12-bit address, one data line from the master toward the slaves, one data line from the slaves back to the master, and a strobe that the master pulses only when it writes. The slave splits the address into two fields. The upper field is compared with a base value that comes in on configuration inputs, in the way a board sets a value with DIP switches. The lower field picks one bit position inside the device.

A write takes place once for each strobe pulse. The strobe is sampled on the system clock. On the clock edge where the sampled strobe first reads high, the master's data bit is stored into the output latch chosen by the lower address field. A read needs no strobe. While the device is selected, the return line shows the chosen status input combinationally, and a read never alters the latches. A separate enable output tells the board when to drive the shared return line.

Top module: `bitbus_slave`

## Requirements
- R1: A synchronous reset (`rst` high on a rising clock edge) clears every output latch to 0.
- R2: `bus_din_oe` is 1 exactly when `bus_addr[11:8]` equals `base_sel`, and 0 otherwise.
- R3: On the first clock edge where `bus_strobe` is sampled high after being low, with the device selected and `bus_addr[7:0]` below 16, `latch_q[bus_addr[3:0]]` takes the value of `bus_dout`.
- R4: Each strobe pulse gives exactly one write. While `bus_strobe` stays high on later edges, the latches keep their values even if `bus_dout` or `bus_addr` changes.
- R5: A strobe pulse while `bus_addr[11:8]` differs from `base_sel` leaves every latch unchanged.
- R6: A strobe pulse to a selected position from 16 to 255 leaves every latch unchanged.
- R7: While selected, with `bus_addr[7:0]` below 16, `bus_din` equals `stat_in[bus_addr[3:0]]` in the same cycle.
- R8: `bus_din` is 0 when the device is not selected, or when `bus_addr[7:0]` is 16 or higher.
- R9: Address and data activity with `bus_strobe` low (reads) leaves every latch unchanged.
- R10: A write changes at most the one addressed latch bit.
- R11: A change of `base_sel` takes effect at once for both selection and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Bus address: upper 4 bits device field, lower 8 bits bit position |
| base_sel | input | 4 | Configured base value compared with the upper address field |
| bus_dout | input | 1 | Data bit from master toward slaves |
| bus_strobe | input | 1 | Write strobe from master |
| stat_in | input | 16 | Status inputs readable by the master |
| bus_din | output | 1 | Data bit returned to master |
| bus_din_oe | output | 1 | Enable for driving the shared return line |
| latch_q | output | 16 | Output latches written by the master |

## Verification
The bench builds the block with its default parameters: a 12-bit address, an 8-bit position field, and 16 latches and 16 status inputs. With these values the whole read space of both a matching and a non-matching device field can be swept one address per cycle, and every latch can be written and cleared. The 240 unimplemented positions lie next to the real ones, so the boundary at 15/16 and the far end at 255 are both tested. Long strobe pulses with data that changes during the pulse, and a base value changed during the run, test the single-write rule and the live decode.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int DEF_ADDR_W = 12;
  localparam int DEF_SEL_W  = 8;
  localparam int DEF_N_OUT  = 16;
  localparam int DEF_N_IN   = 16;

  typedef struct packed {
    logic hit;
    logic fire;
  } bbs_ctl_t;
endpackage

// File: rtl/bbs_decode.sv
module bbs_decode #(
  parameter int ADDR_W = bbs_pkg::DEF_ADDR_W,
  parameter int SEL_W  = bbs_pkg::DEF_SEL_W,
  localparam int BASE_W = ADDR_W - SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic [SEL_W-1:0]  idx
);
  always_comb begin
    hit = (addr[ADDR_W-1:SEL_W] == base);
    idx = addr[SEL_W-1:0];
  end
endmodule

// File: rtl/bbs_strobe_edge.sv
module bbs_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/bbs_latch_bank.sv
module bbs_latch_bank #(
  parameter int SEL_W = bbs_pkg::DEF_SEL_W,
  parameter int N_OUT = bbs_pkg::DEF_N_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] idx,
  input  logic             d,
  output logic [N_OUT-1:0] q
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    logic hit_i;
    assign hit_i = we && (idx == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= 1'b0;
      else if (hit_i) q[i] <= d;
    end
  end
endmodule

// File: rtl/bbs_read_mux.sv
module bbs_read_mux #(
  parameter int SEL_W = bbs_pkg::DEF_SEL_W,
  parameter int N_IN  = bbs_pkg::DEF_N_IN
) (
  input  logic             hit,
  input  logic [SEL_W-1:0] idx,
  input  logic [N_IN-1:0]  stat,
  output logic             din,
  output logic             oe
);
  logic [N_IN-1:0] pick;

  for (genvar i = 0; i < N_IN; i++) begin : g_pick
    assign pick[i] = stat[i] & (idx == SEL_W'(i));
  end

  assign din = hit & (|pick);
  assign oe  = hit;
endmodule

// File: rtl/bitbus_slave.sv
module bitbus_slave #(
  parameter int ADDR_W = bbs_pkg::DEF_ADDR_W,
  parameter int SEL_W  = bbs_pkg::DEF_SEL_W,
  parameter int N_OUT  = bbs_pkg::DEF_N_OUT,
  parameter int N_IN   = bbs_pkg::DEF_N_IN,
  localparam int BASE_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BASE_W-1:0] base_sel,
  input  logic              bus_dout,
  input  logic              bus_strobe,
  input  logic [N_IN-1:0]   stat_in,
  output logic              bus_din,
  output logic              bus_din_oe,
  output logic [N_OUT-1:0]  latch_q
);
  bbs_pkg::bbs_ctl_t ctl;
  logic [SEL_W-1:0]  idx;
  logic              rise;

  bbs_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_decode (
    .addr (bus_addr),
    .base (base_sel),
    .hit  (ctl.hit),
    .idx  (idx)
  );

  bbs_strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (bus_strobe),
    .rise   (rise)
  );

  assign ctl.fire = rise & ctl.hit;

  bbs_latch_bank #(.SEL_W(SEL_W), .N_OUT(N_OUT)) u_bank (
    .clk (clk),
    .rst (rst),
    .we  (ctl.fire),
    .idx (idx),
    .d   (bus_dout),
    .q   (latch_q)
  );

  bbs_read_mux #(.SEL_W(SEL_W), .N_IN(N_IN)) u_rd (
    .hit  (ctl.hit),
    .idx  (idx),
    .stat (stat_in),
    .din  (bus_din),
    .oe   (bus_din_oe)
  );
endmodule

// File: rtl/bbs_checks.sv
module bbs_checks #(
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 8,
  parameter int N_OUT  = 16,
  localparam int BASE_W = ADDR_W - SEL_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BASE_W-1:0] base_sel,
  input logic              bus_strobe,
  input logic              bus_din,
  input logic              bus_din_oe,
  input logic [N_OUT-1:0]  latch_q
);
  logic sel_now;
  logic hi_idx;
  assign sel_now = (bus_addr[ADDR_W-1:SEL_W] == base_sel);
  assign hi_idx  = (bus_addr[SEL_W-1:0] >= SEL_W'(N_OUT));

  a_r2_oe_tracks_base: assert property (@(posedge clk) disable iff (rst)
    bus_din_oe == sel_now);

  a_r8_quiet_unselected: assert property (@(posedge clk) disable iff (rst)
    !bus_din_oe |-> !bus_din);

  a_r4_one_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bus_strobe && $past(bus_strobe)) |=> $stable(latch_q));

  a_r5_no_write_unmatched: assert property (@(posedge clk) disable iff (rst)
    !sel_now |=> $stable(latch_q));

  a_r6_no_write_high_idx: assert property (@(posedge clk) disable iff (rst)
    (sel_now && hi_idx) |=> $stable(latch_q));

  a_r9_read_no_effect: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe |=> $stable(latch_q));

  a_r10_single_bit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(latch_q ^ $past(latch_q)) <= 1));
endmodule

bind bitbus_slave bbs_checks #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .N_OUT(N_OUT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .base_sel   (base_sel),
  .bus_strobe (bus_strobe),
  .bus_din    (bus_din),
  .bus_din_oe (bus_din_oe),
  .latch_q    (latch_q)
);

// File: tb/test_bitbus_slave.sv
`timescale 1ns/1ps
module test_bitbus_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0]  base = 4'hA;
  logic        dout = 1'b0;
  logic        strobe = 1'b0;
  logic [15:0] stat = '0;
  logic        din, oe;
  logic [15:0] q;

  logic [15:0] ref_q = '0;
  bit          ref_pstb = 1'b0;
  int          checks = 0;
  int          fails = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bitbus_slave i_bitbus_slave (
    .clk(clk), .rst(rst), .bus_addr(addr), .base_sel(base),
    .bus_dout(dout), .bus_strobe(strobe), .stat_in(stat),
    .bus_din(din), .bus_din_oe(oe), .latch_q(q)
  );

  function automatic bit exp_oe();
    return addr[11:8] == base;
  endfunction

  function automatic bit exp_din();
    int k;
    k = int'(addr[7:0]);
    if (addr[11:8] != base) return 1'b0;
    if (k >= 16) return 1'b0;
    return stat[k];
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: one write per strobe rise, selected, position below 16
  always @(posedge clk) begin
    if (rst) begin
      ref_q    = '0;
      ref_pstb = 1'b0;
    end else begin
      if (strobe && !ref_pstb && addr[11:8] == base && int'(addr[7:0]) < 16)
        ref_q[int'(addr[3:0])] = dout;
      ref_pstb = strobe;
    end
  end

  // compare every cycle, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk(cur_req, "latch_q", q, ref_q);
      chk((cur_req == "R7") ? "R2" : cur_req, "bus_din_oe", 16'(oe), 16'(exp_oe()));
      chk((cur_req == "R7") ? "R8" : cur_req, "bus_din", 16'(din), 16'(exp_din()));
    end
  end

  task automatic pulse(input logic [11:0] a, input logic d, input int hold);
    @(negedge clk);
    addr = a; dout = d; strobe = 1'b1;
    repeat (hold) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "latch_q after reset", q, 16'h0000);

    // R3: fill all positions with a pattern
    cur_req = "R3";
    for (int i = 0; i < 16; i++) pulse({4'hA, 8'(i)}, (16'hB6D3 >> i) & 1'b1, 1);
    chk("R3", "pattern stored", q, 16'hB6D3);

    // R10: flip single bits
    cur_req = "R10";
    pulse({4'hA, 8'd5}, 1'b1, 2);
    chk("R10", "bit 5 set only", q, 16'hB6F3);
    pulse({4'hA, 8'd15}, 1'b0, 1);
    chk("R10", "bit 15 cleared only", q, 16'h36F3);

    // R4: long pulse, data and address wander while high
    cur_req = "R4";
    @(negedge clk);
    addr = {4'hA, 8'd2}; dout = 1'b1; strobe = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dout = ~dout;
      addr = {4'hA, 8'(i + 8)};
    end
    strobe = 1'b0;
    @(negedge clk);
    chk("R4", "single write per pulse", q, 16'h36F7);

    // R5: writes with a foreign device field
    cur_req = "R5";
    snap = q;
    for (int i = 0; i < 16; i++) pulse({4'h3, 8'(i)}, ~snap[i], 1);
    chk("R5", "unmatched writes ignored", q, snap);

    // R6: writes to unimplemented positions
    cur_req = "R6";
    pulse({4'hA, 8'd16}, 1'b1, 1);
    pulse({4'hA, 8'd128}, 1'b1, 1);
    pulse({4'hA, 8'd255}, 1'b0, 1);
    pulse({4'hA, 8'd240}, 1'b0, 1);
    chk("R6", "high positions ignored", q, snap);

    // R7/R8/R2: read sweep, selected and unselected
    cur_req = "R7";
    stat = 16'h5A3C;
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        addr = {(u == 0) ? 4'hA : 4'h3, 8'(k)};
        dout = k[0];
      end
    end
    @(negedge clk);
    addr = {4'hA, 8'd3}; stat = 16'h0008;
    #1 chk("R7", "read status bit 3", 16'(din), 16'h0001);
    addr = {4'hA, 8'd19};
    #1 chk("R8", "read position 19", 16'(din), 16'h0000);
    addr = {4'h5, 8'd3};
    #1 chk("R8", "read when unselected", 16'(din), 16'h0000);
    chk("R2", "oe when unselected", 16'(oe), 16'h0000);

    // R9: reads leave latches alone
    cur_req = "R9";
    snap = q;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      addr = 12'(k * 37);
      dout = k[1];
      stat = 16'(k * 911);
    end
    @(negedge clk);
    chk("R9", "latches after reads", q, snap);

    // R11: change base at run time
    cur_req = "R11";
    base = 4'h0;
    pulse({4'h0, 8'd0}, 1'b1, 1);
    pulse({4'hA, 8'd1}, 1'b1, 1);
    chk("R11", "new base writes, old base ignored", q, snap | 16'h0001);
    addr = {4'h0, 8'd4};
    #1 chk("R11", "oe follows new base", 16'(oe), 16'h0001);

    // R1: reset again with latches set
    cur_req = "R1";
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "latch_q cleared by reset", q, 16'h0000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule